// File: doc/BRIEF.md
# Timeout-Bounded Stale Victim Cache

This block is a small, fully associative buffer that sits beside a data L1 cache. It keeps copies of lines that coherence traffic has invalidated. When the L1 later misses on such a line for coherence reasons, the buffer can answer the load at once with the old data. The load does not wait for a coherent refill. The answer is approximate on purpose. Staleness is bounded because every entry is dropped a fixed number of cycles after it was captured.

The L1 offers an evicted line on the insert port together with a flag telling whether that line was in the invalidated state. Only invalidated lines are kept, and each is kept with the data it held when it was invalidated. Lookups are combinational and answer in the same cycle. A store to a buffered address removes that entry, and a flush empties the buffer. When all entries are in use, an insert replaces the oldest one.

Top module: `stale_vc`

## Requirements
- R1: After reset no entry is held: every lookup misses, and on a miss `lkp_hit_o` is 0 and `lkp_data_o` is all zeros.
- R2: An insert is captured only when `ins_valid_i` and `ins_inv_i` are both 1. An evicted line with `ins_inv_i` = 0 leaves the contents unchanged.
- R3: A lookup that matches a live entry raises `lkp_hit_o` in the same cycle as the request and drives that entry's stored data on `lkp_data_o`. `lkp_hit_o` is never 1 without `lkp_valid_i`.
- R4: Age is counted in clock edges since capture, and it is 0 right after the capturing edge. An entry hits while its age is below `TIMEOUT`. In the cycle where its age equals `TIMEOUT` it misses, and it is cleared at the following edge.
- R5: Up to `N_ENTRIES` distinct addresses can be held at once, because an insert takes a free entry whenever one exists.
- R6: An insert into a full buffer replaces the entry with the largest age. That address then misses, and all the other entries keep hitting.
- R7: Inserting an address that already matches a live entry overwrites that entry's data and resets its age to 0, so the address can hit past its original expiry time.
- R8: A store (`st_valid_i`) whose address matches an entry clears that entry from the next cycle on, and other entries are not affected. A lookup in the same cycle as the store still sees the old contents.
- R9: `flush_i` clears every entry from the next cycle on.
- R10: A lookup made in the same cycle as an insert to the same address sees the state from before the insert: a miss for a new address, or the old data for an overwrite.
- R11: An insert is dropped when `flush_i` is high in the same cycle, or when a store to the same address is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | L1 eviction offered this cycle |
| ins_inv_i | input | 1 | The evicted line is in the invalidated state |
| ins_addr_i | input | ADDR_W | Line address of the evicted line |
| ins_data_i | input | DATA_W | Line data as it was at invalidation |
| lkp_valid_i | input | 1 | Coherence load miss requests a stale answer |
| lkp_addr_i | input | ADDR_W | Line address of the lookup |
| lkp_hit_o | output | 1 | Lookup matched a live entry |
| lkp_data_o | output | DATA_W | Stale line data on a hit, zero otherwise |
| st_valid_i | input | 1 | Store to a line address this cycle |
| st_addr_i | input | ADDR_W | Line address of the store |
| flush_i | input | 1 | Clear every entry |

## Verification
The assertions assume that `TIMEOUT` is at least 1. They also assume that any address the bench looks up right after an insert or a store is judged only against that one-cycle history, so a lookup to an unrelated address is never constrained. The stimulus drives each operation for one full cycle and changes inputs only half a cycle away from the active edge. Every lookup that follows a capture falls inside the live window, except in the expiry test, which walks the age counter deliberately up to `TIMEOUT` and beyond. Same-cycle combinations of insert with store, flush or lookup are applied only in the mixes that R10 and R11 define.

// File: rtl/stale_vc_pkg.sv
package stale_vc_pkg;
  typedef enum logic [1:0] {
    PICK_NONE   = 2'd0,
    PICK_MATCH  = 2'd1,
    PICK_FREE   = 2'd2,
    PICK_OLDEST = 2'd3
  } pick_e;
endpackage

// File: rtl/svc_entry.sv
module svc_entry #(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 512,
  parameter int TIMEOUT = 1024,
  parameter int AGE_W   = $clog2(TIMEOUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              kill_i,
  output logic              live_o,
  output logic              occ_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic [DATA_W-1:0] data_o,
  output logic [AGE_W-1:0]  age_o
);
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(TIMEOUT);

  logic              vld_q;
  logic [AGE_W-1:0]  age_q;
  logic [ADDR_W-1:0] tag_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      age_q <= '0;
      tag_q <= '0;
      dat_q <= '0;
    end else if (wr_i) begin
      vld_q <= 1'b1;
      age_q <= '0;
      tag_q <= addr_i;
      dat_q <= data_i;
    end else begin
      if (kill_i || (vld_q && age_q >= AGE_LIM)) vld_q <= 1'b0;
      if (vld_q && age_q < AGE_LIM) age_q <= age_q + 1'b1;
    end
  end

  assign live_o = vld_q && (age_q < AGE_LIM);
  assign occ_o  = vld_q;
  assign tag_o  = tag_q;
  assign data_o = dat_q;
  assign age_o  = age_q;
endmodule

// File: rtl/svc_ins_sel.sv
module svc_ins_sel
  import stale_vc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int AGE_W     = 11
) (
  input  logic [N_ENTRIES-1:0]            live_i,
  input  logic [N_ENTRIES-1:0]            match_i,
  input  logic [N_ENTRIES-1:0][AGE_W-1:0] age_i,
  output logic [N_ENTRIES-1:0]            sel_o,
  output pick_e                           pick_o
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [IDX_W-1:0] free_idx, old_idx, match_idx;
  logic [AGE_W-1:0] old_age;
  logic             any_free, any_match;

  always_comb begin
    any_free  = 1'b0;
    any_match = 1'b0;
    free_idx  = '0;
    match_idx = '0;
    old_idx   = '0;
    old_age   = age_i[0];
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (!live_i[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (match_i[i]) begin
        any_match = 1'b1;
        match_idx = IDX_W'(i);
      end
    end
    for (int i = 1; i < N_ENTRIES; i++) begin
      if (age_i[i] > old_age) begin
        old_age = age_i[i];
        old_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    sel_o = '0;
    if (any_match) begin
      pick_o = PICK_MATCH;
      sel_o[match_idx] = 1'b1;
    end else if (any_free) begin
      pick_o = PICK_FREE;
      sel_o[free_idx] = 1'b1;
    end else begin
      pick_o = PICK_OLDEST;
      sel_o[old_idx] = 1'b1;
    end
  end
endmodule

// File: rtl/svc_lookup.sv
module svc_lookup #(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 512
) (
  input  logic                             req_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [N_ENTRIES-1:0]             live_i,
  input  logic [N_ENTRIES-1:0][ADDR_W-1:0] tag_i,
  input  logic [N_ENTRIES-1:0][DATA_W-1:0] data_i,
  output logic                             hit_o,
  output logic [DATA_W-1:0]                data_o
);
  logic [N_ENTRIES-1:0] hv;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hv[g] = req_i && live_i[g] && (tag_i[g] == addr_i);
  end

  // live tags are unique, so an OR mux suffices
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_ENTRIES; i++)
      if (hv[i]) data_o = data_o | data_i[i];
  end

  assign hit_o = |hv;
endmodule

// File: rtl/stale_vc.sv
module stale_vc
  import stale_vc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 512,
  parameter int TIMEOUT   = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_valid_i,
  input  logic              ins_inv_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [DATA_W-1:0] ins_data_i,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  output logic              lkp_hit_o,
  output logic [DATA_W-1:0] lkp_data_o,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              flush_i
);
  localparam int AGE_W = $clog2(TIMEOUT + 1);

  logic [N_ENTRIES-1:0]             live, occ, match, sel, wr, kill;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] tag;
  logic [N_ENTRIES-1:0][DATA_W-1:0] dat;
  logic [N_ENTRIES-1:0][AGE_W-1:0]  age;
  logic                             ins_go;
  pick_e                            pick;

  assign ins_go = ins_valid_i && ins_inv_i && !flush_i &&
                  !(st_valid_i && (st_addr_i == ins_addr_i));

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    assign match[g] = live[g] && (tag[g] == ins_addr_i);
    assign wr[g]    = ins_go && sel[g];
    assign kill[g]  = flush_i || (st_valid_i && occ[g] && (tag[g] == st_addr_i));

    svc_entry #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .TIMEOUT(TIMEOUT),
      .AGE_W  (AGE_W)
    ) u_ent (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (wr[g]),
      .addr_i(ins_addr_i),
      .data_i(ins_data_i),
      .kill_i(kill[g]),
      .live_o(live[g]),
      .occ_o (occ[g]),
      .tag_o (tag[g]),
      .data_o(dat[g]),
      .age_o (age[g])
    );
  end

  svc_ins_sel #(
    .N_ENTRIES(N_ENTRIES),
    .AGE_W    (AGE_W)
  ) u_sel (
    .live_i (live),
    .match_i(match),
    .age_i  (age),
    .sel_o  (sel),
    .pick_o (pick)
  );

  svc_lookup #(
    .N_ENTRIES(N_ENTRIES),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_lkp (
    .req_i (lkp_valid_i),
    .addr_i(lkp_addr_i),
    .live_i(live),
    .tag_i (tag),
    .data_i(dat),
    .hit_o (lkp_hit_o),
    .data_o(lkp_data_o)
  );
endmodule

// File: rtl/stale_vc_chk.sv
module stale_vc_chk #(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 512,
  parameter int TIMEOUT = 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ins_valid_i,
  input logic              ins_inv_i,
  input logic [ADDR_W-1:0] ins_addr_i,
  input logic [DATA_W-1:0] ins_data_i,
  input logic              lkp_valid_i,
  input logic [ADDR_W-1:0] lkp_addr_i,
  input logic              lkp_hit_o,
  input logic [DATA_W-1:0] lkp_data_o,
  input logic              st_valid_i,
  input logic [ADDR_W-1:0] st_addr_i,
  input logic              flush_i
);
  initial begin
    AST_TIMEOUT_MIN: assert (TIMEOUT >= 1); // R4
  end

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> lkp_valid_i); // R3

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> (lkp_data_o == '0)); // R1

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lkp_hit_o); // R9

  AST_STORE_REMOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |=> !(lkp_hit_o && (lkp_addr_i == $past(st_addr_i)))); // R8

  AST_INSERT_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_inv_i && !flush_i && !(st_valid_i && st_addr_i == ins_addr_i))
    |=> (!(lkp_valid_i && lkp_addr_i == $past(ins_addr_i)) ||
         (lkp_hit_o && lkp_data_o == $past(ins_data_i)))); // R2
endmodule

bind stale_vc stale_vc_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .TIMEOUT(TIMEOUT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ins_valid_i(ins_valid_i),
  .ins_inv_i  (ins_inv_i),
  .ins_addr_i (ins_addr_i),
  .ins_data_i (ins_data_i),
  .lkp_valid_i(lkp_valid_i),
  .lkp_addr_i (lkp_addr_i),
  .lkp_hit_o  (lkp_hit_o),
  .lkp_data_o (lkp_data_o),
  .st_valid_i (st_valid_i),
  .st_addr_i  (st_addr_i),
  .flush_i    (flush_i)
);

// File: tb/sim_stale_vc.sv
`timescale 1ns/1ps
module sim_stale_vc;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TO = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_v = 1'b0, ins_inv = 1'b0, lkp_v = 1'b0, st_v = 1'b0, flush = 1'b0;
  logic [AW-1:0] ins_a = '0, lkp_a = '0, st_a = '0;
  logic [DW-1:0] ins_d = '0;
  logic          hit;
  logic [DW-1:0] rdat;
  int            n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  stale_vc #(.N_ENTRIES(N), .ADDR_W(AW), .DATA_W(DW), .TIMEOUT(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_v), .ins_inv_i(ins_inv), .ins_addr_i(ins_a), .ins_data_i(ins_d),
    .lkp_valid_i(lkp_v), .lkp_addr_i(lkp_a), .lkp_hit_o(hit), .lkp_data_o(rdat),
    .st_valid_i(st_v), .st_addr_i(st_a), .flush_i(flush)
  );

  typedef struct packed {
    logic iv; logic inv; logic [AW-1:0] ia; logic [DW-1:0] id;
    logic lv; logic [AW-1:0] la; logic sv; logic [AW-1:0] sa; logic fl;
    logic eh; logic [DW-1:0] ed;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,16'h0000,32'h0,        1'b1,16'h0010,1'b0,16'h0,1'b0, 1'b0,32'h0},        // R1 empty
    '{1'b1,1'b0,16'h0010,32'hAAAA0000, 1'b1,16'h0010,1'b0,16'h0,1'b0, 1'b0,32'h0},        // R2 valid line offered
    '{1'b0,1'b0,16'h0000,32'h0,        1'b1,16'h0010,1'b0,16'h0,1'b0, 1'b0,32'h0},        // R2 not captured
    '{1'b1,1'b1,16'h0010,32'h11111111, 1'b1,16'h0010,1'b0,16'h0,1'b0, 1'b0,32'h0},        // R10 new addr
    '{1'b0,1'b0,16'h0000,32'h0,        1'b1,16'h0010,1'b0,16'h0,1'b0, 1'b1,32'h11111111}, // R3 hit
    '{1'b1,1'b1,16'h0010,32'h22222222, 1'b1,16'h0010,1'b0,16'h0,1'b0, 1'b1,32'h11111111}, // R10 old data
    '{1'b0,1'b0,16'h0000,32'h0,        1'b1,16'h0010,1'b0,16'h0,1'b0, 1'b1,32'h22222222}, // R7 overwrite
    '{1'b1,1'b1,16'h0020,32'h33333333, 1'b1,16'h0010,1'b1,16'h0020,1'b0, 1'b1,32'h22222222}, // R11 store same addr
    '{1'b0,1'b0,16'h0000,32'h0,        1'b1,16'h0020,1'b0,16'h0,1'b0, 1'b0,32'h0},        // R11 dropped
    '{1'b0,1'b0,16'h0000,32'h0,        1'b1,16'h0010,1'b1,16'h0010,1'b0, 1'b1,32'h22222222}, // R8 same cycle old
    '{1'b0,1'b0,16'h0000,32'h0,        1'b1,16'h0010,1'b0,16'h0,1'b0, 1'b0,32'h0},        // R8 removed
    '{1'b1,1'b1,16'h0030,32'h44444444, 1'b1,16'h0030,1'b0,16'h0,1'b0, 1'b0,32'h0},        // R10
    '{1'b1,1'b1,16'h0040,32'h55555555, 1'b1,16'h0030,1'b0,16'h0,1'b0, 1'b1,32'h44444444}, // R3
    '{1'b1,1'b1,16'h0050,32'h66666666, 1'b1,16'h0040,1'b0,16'h0,1'b1, 1'b1,32'h55555555}, // R11 flush with insert
    '{1'b0,1'b0,16'h0000,32'h0,        1'b1,16'h0030,1'b0,16'h0,1'b0, 1'b0,32'h0},        // R9
    '{1'b0,1'b0,16'h0000,32'h0,        1'b1,16'h0050,1'b0,16'h0,1'b0, 1'b0,32'h0},        // R11 flush dropped insert
    '{1'b0,1'b0,16'h0000,32'h0,        1'b1,16'h0040,1'b0,16'h0,1'b0, 1'b0,32'h0}         // R9
  };

  task automatic check(input string req, input logic eh, input logic [DW-1:0] ed);
    n_chk++;
    if (hit !== eh || rdat !== (eh ? ed : '0)) begin
      n_err++;
      $display("FAIL %s: hit=%0b data=%h expected hit=%0b data=%h", req, hit, rdat, eh, eh ? ed : '0);
    end
  endtask

  // drive at negedge, sample 1 ns later, commit at next posedge
  task automatic cyc(input logic iv, input logic inv, input logic [AW-1:0] ia, input logic [DW-1:0] id,
                     input logic lv, input logic [AW-1:0] la, input logic sv, input logic [AW-1:0] sa,
                     input logic fl, input logic do_chk, input logic eh, input logic [DW-1:0] ed,
                     input string req);
    @(negedge clk);
    ins_v = iv; ins_inv = inv; ins_a = ia; ins_d = id;
    lkp_v = lv; lkp_a = la; st_v = sv; st_a = sa; flush = fl;
    #1;
    if (do_chk) check(req, eh, ed);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "");
  endtask

  task automatic ins(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "");
  endtask

  task automatic look(input logic [AW-1:0] a, input logic eh, input logic [DW-1:0] ed, input string req);
    cyc(1'b0, 1'b0, '0, '0, 1'b1, a, 1'b0, '0, 1'b0, 1'b1, eh, ed, req);
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #10;
    lkp_v = 1'b1; lkp_a = 16'h0010;
    #1 check("R1 reset", 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      cyc(VECS[i].iv, VECS[i].inv, VECS[i].ia, VECS[i].id, VECS[i].lv, VECS[i].la,
          VECS[i].sv, VECS[i].sa, VECS[i].fl, 1'b1, VECS[i].eh, VECS[i].ed, $sformatf("vector %0d", i));

    // R4 expiry window
    ins(16'h0077, 32'h77777777);
    for (int j = 0; j <= TO + 1; j++)
      look(16'h0077, j < TO, 32'h77777777, $sformatf("R4 age %0d", j));

    // R5 capacity, then R6 oldest replaced
    for (int i = 0; i < N; i++) ins(AW'(16'h0100 + i), DW'(32'hC0DE0000 + i));
    for (int i = 0; i < N; i++) look(AW'(16'h0100 + i), 1'b1, DW'(32'hC0DE0000 + i), "R5 all held");
    ins(16'h0200, 32'hBEEF0200);
    look(16'h0100, 1'b0, '0, "R6 oldest evicted");
    for (int i = 1; i < N; i++) look(AW'(16'h0100 + i), 1'b1, DW'(32'hC0DE0000 + i), "R6 others kept");
    look(16'h0200, 1'b1, 32'hBEEF0200, "R6 new entry");

    // R7 overwrite resets age
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b0, '0, "");
    ins(16'h0300, 32'h30303030);
    for (int j = 0; j < TO - 4; j++) idle();
    ins(16'h0300, 32'h31313131);
    for (int j = 0; j < 8; j++) idle();
    look(16'h0300, 1'b1, 32'h31313131, "R7 age reset");

    // R8 store leaves other entries alone
    ins(16'h0400, 32'h40404040);
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b1, 16'h0300, 1'b0, 1'b0, 1'b0, '0, "");
    look(16'h0300, 1'b0, '0, "R8 store cleared");
    look(16'h0400, 1'b1, 32'h40404040, "R8 neighbour kept");

    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule